// File: doc/BRIEF.md
# ISDN 2B+D Serial Framer

This block carries one basic-rate ISDN payload frame, two 8-bit bearer bytes and a 2-bit signalling field, across a serial data port once per frame-sync period. On the transmit side it takes the two bytes and the signalling field in parallel, captures them at the start of the frame and shifts them out one bit per data clock. On the receive side it samples the serial input using the same slot layout and presents the recovered bytes and signalling field in parallel, with a one-cycle strobe once the frame is complete.

The data clock and the frame-sync strobe come from outside the block. Three control inputs set how the frame is laid out: one selects between a packed layout (both bytes back to back, then both signalling bits) and an interleaved layout (one signalling bit after each byte). One exchanges the slots of the two bearer bytes. One inverts every bit on the line in both directions. All three are captured at frame start, together with the transmit data, so that a frame is never torn by a change in mid-frame. Outside the 18 payload slots the serial output is released, shown by a low output enable.

Top module: `isdn_2bd_framer`

## Requirements
- R1: A high `fsync_i` seen at a rising clock edge starts a frame; slot 0 appears on `sdo_o` right after that edge and slots 1 to 17 follow, one per clock. `sdo_oe_o` is high for exactly those 18 clocks and low otherwise.
- R2: With `oct_mode_i` = 1 (packed layout), slots 0-7 carry the first byte MSB first, slots 8-15 the second byte MSB first, slot 16 carries D bit 1 and slot 17 carries D bit 0.
- R3: With `oct_mode_i` = 0 (interleaved layout), slots 0-7 carry the first byte MSB first, slot 8 carries D bit 1, slots 9-16 the second byte MSB first and slot 17 carries D bit 0.
- R4: With `bswap_i` = 0 the first byte is B1 and the second B2; with `bswap_i` = 1 they are exchanged, in both layouts.
- R5: With `inv_i` = 1 every transmitted slot is the complement of the value R2 to R4 give.
- R6: The receiver samples `sdi_i` on the falling clock edge inside each slot and decodes B1, B2 and D by the same layout and swap rules as the transmitter.
- R7: With `inv_i` = 1 every received bit is complemented before decoding.
- R8: `rx_done_o` pulses high for one clock right after the rising edge that ends slot 17; the received values on `rx_b1_o`, `rx_b2_o` and `rx_d_o` are updated at that edge and then hold until the next frame completes.
- R9: The transmit data and the three controls are captured when the frame starts; changing them during the frame has no effect on that frame in either direction.
- R10: During and after reset, with no frame sync, `sdo_oe_o` and `rx_done_o` are low and the received outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock from outside the block |
| rst_n | input | 1 | Synchronous reset, active low |
| fsync_i | input | 1 | Frame-sync strobe, marks slot 0 |
| oct_mode_i | input | 1 | 1 = packed layout, 0 = interleaved layout |
| bswap_i | input | 1 | 1 = exchange B1 and B2 slots |
| inv_i | input | 1 | 1 = complement all line bits |
| tx_b1_i | input | 8 | B1 byte to send |
| tx_b2_i | input | 8 | B2 byte to send |
| tx_d_i | input | 2 | D field to send |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |
| rx_b1_o | output | 8 | Received B1 byte |
| rx_b2_o | output | 8 | Received B2 byte |
| rx_d_o | output | 2 | Received D field |
| rx_done_o | output | 1 | One-cycle strobe, received frame complete |

## Verification
The bench drives each combination of layout, swap and inversion with asymmetric byte and D values, so a design that misplaces a D slot, leaves swap out of one layout or applies inversion in only one direction produces a wrong slot on the line or a wrong decoded value. Some frames change the transmit data and all three controls in the middle of the frame; a design that reads them live would tear the frame. The enable is checked in the clock after slot 17, catching a counter that runs one slot long or short, and the received values are checked again a few clocks after the strobe to catch outputs that do not hold.

// File: rtl/ifr_pkg.sv
// Shared constants, types and slot-layout functions for the 2B+D framer.
// Assumes two bearer bytes and a 2-bit signalling field per frame.
package ifr_pkg;
    localparam int B_W        = 8;
    localparam int D_W        = 2;
    localparam int FRAME_BITS = 2 * B_W + D_W;
    localparam int LAST_SLOT  = FRAME_BITS - 1;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef logic [FRAME_BITS-1:0] slot_vec_t;

    typedef struct packed {
        logic oct;
        logic swap;
        logic inv;
    } cfg_t;

    typedef struct packed {
        logic [B_W-1:0] b1;
        logic [B_W-1:0] b2;
        logic [D_W-1:0] d;
    } payload_t;

    // Place a payload into slot order (index = slot number).
    function automatic slot_vec_t pack_slots(payload_t p, logic oct, logic swap);
        slot_vec_t      v;
        logic [B_W-1:0] first;
        logic [B_W-1:0] second;
        int             base2;
        int             dhi;
        first  = swap ? p.b2 : p.b1;
        second = swap ? p.b1 : p.b2;
        base2  = oct ? B_W : B_W + 1;
        dhi    = oct ? 2 * B_W : B_W;
        v      = '0;
        for (int i = 0; i < B_W; i++) begin
            v[i]         = first[B_W-1-i];
            v[base2 + i] = second[B_W-1-i];
        end
        v[dhi]       = p.d[1];
        v[LAST_SLOT] = p.d[0];
        return v;
    endfunction

    // Recover a payload from slot order.
    function automatic payload_t unpack_slots(slot_vec_t v, logic oct, logic swap);
        payload_t       p;
        logic [B_W-1:0] first;
        logic [B_W-1:0] second;
        int             base2;
        int             dhi;
        base2 = oct ? B_W : B_W + 1;
        dhi   = oct ? 2 * B_W : B_W;
        for (int i = 0; i < B_W; i++) begin
            first[B_W-1-i]  = v[i];
            second[B_W-1-i] = v[base2 + i];
        end
        p.b1 = swap ? second : first;
        p.b2 = swap ? first : second;
        p.d  = {v[dhi], v[LAST_SLOT]};
        return p;
    endfunction
endpackage

// File: rtl/ifr_seq.sv
// Slot sequencer: starts a frame on frame sync, counts 18 slots and holds
// the controls captured at frame start. Assumes fsync is synchronous to clk.
module ifr_seq
    import ifr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    input  cfg_t             cfg_i,
    output logic             active_o,
    output logic [CNT_W-1:0] cnt_o,
    output cfg_t             cfg_o
);
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    cfg_t             cfg_q;

    // Track the slot position and capture the controls at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            cfg_q    <= '0;
        end else if (fsync_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            cfg_q    <= cfg_i;
        end else if (active_q) begin
            if (cnt_q == CNT_W'(LAST_SLOT)) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign cnt_o    = cnt_q;
    assign cfg_o    = cfg_q;

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q <= CNT_W'(LAST_SLOT)));
    // R1
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> (active_q && cnt_q == '0));
endmodule

// File: rtl/ifr_tx.sv
// Transmit path: captures the payload in slot order at frame start and
// drives one slot per clock. Assumes the sequencer's slot count.
module ifr_tx
    import ifr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  cfg_t             cfg_i,
    input  payload_t         payload_i,
    output logic             sdo_o,
    output logic             oe_o
);
    slot_vec_t vec_q;

    // Capture the laid-out, optionally inverted frame at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (start_i) begin
            vec_q <= pack_slots(payload_i, cfg_i.oct, cfg_i.swap)
                     ^ {FRAME_BITS{cfg_i.inv}};
        end
    end

    // Drive the current slot while the frame is active.
    always_comb begin
        oe_o  = active_i;
        sdo_o = active_i ? vec_q[cnt_i] : 1'b0;
    end

    // R9
    payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !start_i) |=> $stable(vec_q));
endmodule

// File: rtl/ifr_rx.sv
// Receive path: samples the line on the falling edge, assembles the slots
// and decodes them after the last slot. Assumes sequencer state is stable
// at the falling edge.
module ifr_rx
    import ifr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  cfg_t             cfg_i,
    input  logic             sdi_i,
    output payload_t         payload_o,
    output logic             done_o
);
    logic             smp_vld_q;
    logic             smp_bit_q;
    logic [CNT_W-1:0] smp_idx_q;
    slot_vec_t        asm_q;
    slot_vec_t        asm_next;
    payload_t         out_q;
    logic             done_q;

    // Sample the line mid-slot and note which slot it belongs to.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            smp_vld_q <= 1'b0;
            smp_bit_q <= 1'b0;
            smp_idx_q <= '0;
        end else begin
            smp_vld_q <= active_i;
            smp_bit_q <= sdi_i ^ cfg_i.inv;
            smp_idx_q <= cnt_i;
        end
    end

    // Merge the newest sample into the assembled frame.
    always_comb begin
        asm_next            = asm_q;
        asm_next[smp_idx_q] = smp_bit_q;
    end

    // Store samples and publish the decoded frame after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_q  <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (smp_vld_q) begin
                asm_q <= asm_next;
                if (smp_idx_q == CNT_W'(LAST_SLOT)) begin
                    out_q  <= unpack_slots(asm_next, cfg_i.oct, cfg_i.swap);
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign payload_o = out_q;
    assign done_o    = done_q;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> $stable(out_q));
endmodule

// File: rtl/isdn_2bd_framer.sv
// Top of the 2B+D serial framer: sequencer, transmit and receive paths.
// Assumes clk is the external data clock and fsync is aligned to it.
module isdn_2bd_framer
    import ifr_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fsync_i,
    input  logic           oct_mode_i,
    input  logic           bswap_i,
    input  logic           inv_i,
    input  logic [B_W-1:0] tx_b1_i,
    input  logic [B_W-1:0] tx_b2_i,
    input  logic [D_W-1:0] tx_d_i,
    input  logic           sdi_i,
    output logic           sdo_o,
    output logic           sdo_oe_o,
    output logic [B_W-1:0] rx_b1_o,
    output logic [B_W-1:0] rx_b2_o,
    output logic [D_W-1:0] rx_d_o,
    output logic           rx_done_o
);
    cfg_t             cfg_live;
    cfg_t             cfg_frame;
    payload_t         tx_pl;
    payload_t         rx_pl;
    logic             active;
    logic [CNT_W-1:0] cnt;

    // Gather the control and payload inputs into packed form.
    always_comb begin
        cfg_live.oct  = oct_mode_i;
        cfg_live.swap = bswap_i;
        cfg_live.inv  = inv_i;
        tx_pl.b1      = tx_b1_i;
        tx_pl.b2      = tx_b2_i;
        tx_pl.d       = tx_d_i;
    end

    ifr_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync_i  (fsync_i),
        .cfg_i    (cfg_live),
        .active_o (active),
        .cnt_o    (cnt),
        .cfg_o    (cfg_frame)
    );

    ifr_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (fsync_i),
        .active_i  (active),
        .cnt_i     (cnt),
        .cfg_i     (cfg_live),
        .payload_i (tx_pl),
        .sdo_o     (sdo_o),
        .oe_o      (sdo_oe_o)
    );

    ifr_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .cnt_i     (cnt),
        .cfg_i     (cfg_frame),
        .sdi_i     (sdi_i),
        .payload_o (rx_pl),
        .done_o    (rx_done_o)
    );

    assign rx_b1_o = rx_pl.b1;
    assign rx_b2_o = rx_pl.b2;
    assign rx_d_o  = rx_pl.d;

    // R1
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe_o) |-> $past(fsync_i));
    // R8
    done_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_o |-> $past(sdo_oe_o));
endmodule

// File: tb/sim_isdn_2bd_framer.sv
// Scoreboard bench: the driver checks the serial output slot by slot and
// queues the expected received frame; the monitor compares on each strobe.
module sim_isdn_2bd_framer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync_i = 1'b0;
    logic       oct_mode_i = 1'b0;
    logic       bswap_i = 1'b0;
    logic       inv_i = 1'b0;
    logic [7:0] tx_b1_i = '0;
    logic [7:0] tx_b2_i = '0;
    logic [1:0] tx_d_i = '0;
    logic       sdi_i = 1'b0;
    logic       sdo_o;
    logic       sdo_oe_o;
    logic [7:0] rx_b1_o;
    logic [7:0] rx_b2_o;
    logic [1:0] rx_d_o;
    logic       rx_done_o;

    int errors = 0;
    int checks = 0;
    logic [17:0] exp_q[$];
    logic [17:0] last_rx = '0;

    always #4 clk = ~clk;

    isdn_2bd_framer u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected line bit of slot k, written from the layout requirements.
    function automatic logic slot_bit(input logic [7:0] b1, input logic [7:0] b2,
                                      input logic [1:0] d, input logic oct,
                                      input logic sw, input int k);
        logic [7:0] f;
        logic [7:0] s;
        f = sw ? b2 : b1;
        s = sw ? b1 : b2;
        if (k < 8) return f[7-k];
        if (oct) begin
            if (k < 16) return s[15-k];
            return (k == 16) ? d[1] : d[0];
        end
        if (k == 8) return d[1];
        if (k < 17) return s[16-k];
        return d[0];
    endfunction

    task automatic run_frame(input logic [7:0] tb1, input logic [7:0] tb2, input logic [1:0] td,
                             input logic oct, input logic sw, input logic inv,
                             input logic [7:0] rb1, input logic [7:0] rb2, input logic [1:0] rd,
                             input bit disturb);
        string req;
        req = disturb ? "R9" : inv ? "R5" : sw ? "R4" : oct ? "R2" : "R3";
        @(posedge clk); #1;
        fsync_i = 1'b1; oct_mode_i = oct; bswap_i = sw; inv_i = inv;
        tx_b1_i = tb1; tx_b2_i = tb2; tx_d_i = td;
        exp_q.push_back({rb1, rb2, rd});
        @(posedge clk);
        for (int k = 0; k < 18; k++) begin
            #1;
            fsync_i = 1'b0;
            sdi_i = slot_bit(rb1, rb2, rd, oct, sw, k) ^ inv;
            if (disturb && k == 3) begin
                tx_b1_i = ~tb1; tx_d_i = ~td;
                oct_mode_i = ~oct; bswap_i = ~sw; inv_i = ~inv;
            end
            #1;
            check(sdo_oe_o == 1'b1, "R1", sdo_oe_o, 1);
            check(sdo_o == (slot_bit(tb1, tb2, td, oct, sw, k) ^ inv), req,
                  sdo_o, slot_bit(tb1, tb2, td, oct, sw, k) ^ inv);
            @(posedge clk);
        end
        #2;
        check(sdo_oe_o == 1'b0, "R1", sdo_oe_o, 0);
        repeat (3) @(posedge clk);
        #2;
        check({rx_b1_o, rx_b2_o, rx_d_o} == {rb1, rb2, rd}, "R8",
              {rx_b1_o, rx_b2_o, rx_d_o}, {rb1, rb2, rd});
    endtask

    // Monitor: compare each completed receive frame against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && rx_done_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", 1, 0);
                end else begin
                    last_rx = exp_q.pop_front();
                    // R6 / R7: decoded B1, B2 and D
                    check({rx_b1_o, rx_b2_o, rx_d_o} == last_rx, inv_i ? "R7" : "R6",
                          {rx_b1_o, rx_b2_o, rx_d_o}, last_rx);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        check(sdo_oe_o == 1'b0, "R10", sdo_oe_o, 0);
        check(rx_done_o == 1'b0, "R10", rx_done_o, 0);
        check({rx_b1_o, rx_b2_o, rx_d_o} == '0, "R10", {rx_b1_o, rx_b2_o, rx_d_o}, 0);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check(sdo_oe_o == 1'b0 && rx_done_o == 1'b0, "R10", {sdo_oe_o, rx_done_o}, 0);

        run_frame(8'hA5, 8'h3C, 2'b10, 1, 0, 0, 8'h81, 8'h7E, 2'b01, 0); // R2
        run_frame(8'hC3, 8'h5A, 2'b01, 0, 0, 0, 8'h12, 8'hF0, 2'b10, 0); // R3
        run_frame(8'h0F, 8'hE1, 2'b10, 1, 1, 0, 8'h9C, 8'h27, 2'b11, 0); // R4
        run_frame(8'h96, 8'h4B, 2'b01, 0, 1, 0, 8'h33, 8'hCD, 2'b10, 0); // R4
        run_frame(8'h71, 8'h8E, 2'b10, 0, 0, 1, 8'hB4, 8'h06, 2'b01, 0); // R5 R7
        run_frame(8'h2D, 8'hD2, 2'b01, 1, 1, 1, 8'h5F, 8'hA0, 2'b10, 1); // R9
        run_frame(8'hE7, 8'h18, 2'b10, 0, 1, 0, 8'h44, 8'hBB, 2'b00, 1); // R9
        run_frame(8'h00, 8'hFF, 2'b11, 1, 0, 1, 8'hFF, 8'h00, 2'b00, 0); // R5 R7

        repeat (4) @(posedge clk);
        #3;
        check(exp_q.size() == 0, "R8", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule